// File: doc/BRIEF.md
# LCD Panel Timing Generator with Self-Refresh

This block drives a passive monochrome or grayscale LCD panel. It produces a per-line pulse, a frame marker during the first line pulse of every frame, a shift clock, and a pixel data bus. Pixel words come from an external line buffer through a ready/read handshake. Each word on the 4-bit bus holds two 2-bit pixels. With the default geometry of 320 pixels by 240 lines, that gives 160 shift-clock pulses per line. At a 60 Hz refresh rate the line period is about 69.4 µs.

A self-refresh request bit lets the panel refresh from its own memory. In self-refresh mode the line pulse and frame marker keep their normal cadence. The shift clock and data bus are held low, and no words are read from the buffer. A change of the request only takes effect at the end of a frame. A status output shows the mode actually in force, so software can see when the change has been applied. After self-refresh ends, output resumes at the first word of line 0.

The sequencer is a four-state machine:

- **START**: the single quiet cycle after reset.
- **LOAD**: presents a read to the buffer and waits for data in normal mode.
- **SHIFT**: drives the shift clock high for one cycle.
- **LPULSE**: drives the line pulse for a programmable number of cycles.

Its transitions are:

- **start_go**: START to LOAD.
- **load_hold**: LOAD to LOAD while the buffer is empty.
- **load_adv**: LOAD to SHIFT.
- **shift_next**: SHIFT to LOAD.
- **shift_eol**: SHIFT to LPULSE after the last word of a line.
- **lp_hold**: LPULSE to LPULSE.
- **lp_eol**: LPULSE to LOAD, which is also the frame boundary after the last line.

Top module: `lcd_timing_gen`

## Requirements
- R1: The clock edge on which reset is sampled low puts the block in START. In the cycle after reset is released, line_pulse, frame_mark, shift_clk, buf_rd and srf_active are 0 and pix_data is 0. The first word shown afterwards belongs to line 0.
- R2: Each line gives WORDS = PIX_PER_LINE*BPP/BUS_W shift_clk pulses, each high for exactly one cycle and low for at least one cycle. These are followed by line_pulse high for lp_width cycles, with no shift_clk pulse during line_pulse. lp_width is held stable while line_pulse is high.
- R3: frame_mark is high exactly in the cycles where line_pulse is high for line 0 of a frame.
- R4: pix_data changes only in the cycle in which shift_clk goes high, or when self-refresh begins. It shows the word read at the preceding buffer read. It is held through the whole high phase and on the falling edge of shift_clk.
- R5: buf_rd is high only in a LOAD cycle in normal mode with buf_valid high; buf_data is taken at that edge. In normal mode with buf_valid low, the block waits in LOAD with shift_clk low and pix_data held.
- R6: srf_req = 1 (the self-refresh bit, bit 7 of the control word) takes effect only at the end of the last line pulse of a frame. srf_active then goes to 1 and reports the mode in force.
- R7: In self-refresh mode, shift_clk, buf_rd and pix_data stay 0 and buf_valid is ignored. line_pulse and frame_mark follow the same cycle timing as normal mode with buf_valid always high.
- R8: srf_req = 0 returns the block to normal mode only at a frame end. Output then resumes with the first word of line 0.
- R9: lp_width = 0 gives a line pulse of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| srf_req | input | 1 | Self-refresh request (control bit 7) |
| lp_width | input | LPW_W | Line pulse length in clock cycles (0 means 1) |
| buf_valid | input | 1 | Line buffer has a word ready |
| buf_data | input | BUS_W | Line buffer word |
| buf_rd | output | 1 | Word taken from the line buffer this cycle |
| line_pulse | output | 1 | Line pulse to the panel |
| frame_mark | output | 1 | Frame marker to the panel |
| shift_clk | output | 1 | Panel shift clock |
| pix_data | output | BUS_W | Panel pixel data |
| srf_active | output | 1 | Mode in force: 1 = self-refresh |

## Verification
The hardest case to reach is a request toggled in the middle of a frame while the buffer is stalling. The mode must then switch at exactly one edge, the last line-pulse cycle of the last line. The first word shown after leaving self-refresh must land in line 0.

The bench uses a small geometry so that frames take tens of cycles. It gates buf_valid with an LFSR pattern and flips srf_req at arbitrary points of the frame. It also resets the block while it is in self-refresh. A behavioural model tracks line position, line number and mode, and is compared with every output on every clock.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
    typedef enum logic [1:0] {
        ST_START  = 2'd0,
        ST_LOAD   = 2'd1,
        ST_SHIFT  = 2'd2,
        ST_LPULSE = 2'd3
    } tg_state_e;
endpackage

// File: rtl/lcd_tg_seq.sv
module lcd_tg_seq
    import lcd_tg_pkg::*;
#(
    parameter int WORDS = 160,
    parameter int LINES = 240,
    parameter int LPW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_valid,
    input  logic             srf_mode,
    input  logic [LPW_W-1:0] lp_width,
    output tg_state_e        state,
    output logic             line_first,
    output logic             pop,
    output logic             frame_end
);
    localparam int WCNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int LCNT_W = (LINES > 1) ? $clog2(LINES) : 1;

    tg_state_e          state_nx;
    logic [WCNT_W-1:0]  word_cnt;
    logic [LCNT_W-1:0]  line_cnt;
    logic [LPW_W-1:0]   lp_cnt;
    logic [LPW_W-1:0]   lp_len;
    logic               last_word;
    logic               last_line;
    logic               lp_done;
    logic               load_adv;

    // Zero width is treated as a single-cycle pulse (R9)
    assign lp_len    = (lp_width == '0) ? LPW_W'(1) : lp_width;
    assign lp_done   = (lp_cnt == lp_len - LPW_W'(1));
    assign last_word = (word_cnt == WCNT_W'(WORDS - 1));
    assign last_line = (line_cnt == LCNT_W'(LINES - 1));
    assign load_adv  = srf_mode || buf_valid;

    assign pop        = (state == ST_LOAD) && !srf_mode && buf_valid;
    assign frame_end  = (state == ST_LPULSE) && lp_done && last_line;
    assign line_first = (line_cnt == '0);

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_START:  state_nx = ST_LOAD;
            ST_LOAD:   state_nx = load_adv ? ST_SHIFT : ST_LOAD;
            ST_SHIFT:  state_nx = last_word ? ST_LPULSE : ST_LOAD;
            ST_LPULSE: state_nx = lp_done ? ST_LOAD : ST_LPULSE;
            default:   state_nx = ST_START;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_START;
        else        state <= state_nx;
    end

    // Position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_cnt <= '0;
            line_cnt <= '0;
            lp_cnt   <= '0;
        end else begin
            if (state == ST_SHIFT) begin
                word_cnt <= last_word ? '0 : word_cnt + WCNT_W'(1);
            end
            if (state == ST_LPULSE) begin
                lp_cnt <= lp_done ? '0 : lp_cnt + LPW_W'(1);
                if (lp_done) begin
                    line_cnt <= last_line ? '0 : line_cnt + LCNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/lcd_tg_mode.sv
module lcd_tg_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic srf_req,
    input  logic frame_end,
    output logic srf_mode
);
    // The request is sampled only on the frame boundary (R6, R8)
    always_ff @(posedge clk) begin
        if (!rst_n)         srf_mode <= 1'b0;
        else if (frame_end) srf_mode <= srf_req;
    end
endmodule

// File: rtl/lcd_tg_out.sv
module lcd_tg_out
    import lcd_tg_pkg::*;
#(
    parameter int BUS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tg_state_e        state,
    input  logic             line_first,
    input  logic             pop,
    input  logic             frame_end,
    input  logic             srf_req,
    input  logic             srf_mode,
    input  logic [BUS_W-1:0] buf_data,
    output logic             buf_rd,
    output logic             line_pulse,
    output logic             frame_mark,
    output logic             shift_clk,
    output logic [BUS_W-1:0] pix_data
);
    logic [BUS_W-1:0] data_q;

    // Word register: loaded on each buffer read, cleared on entering self-refresh
    always_ff @(posedge clk) begin
        if (!rst_n)                    data_q <= '0;
        else if (pop)                  data_q <= buf_data;
        else if (frame_end && srf_req) data_q <= '0;
    end

    // Output decode
    always_comb begin
        buf_rd     = pop;
        line_pulse = 1'b0;
        frame_mark = 1'b0;
        shift_clk  = 1'b0;
        pix_data   = data_q;
        unique case (state)
            ST_START:  pix_data   = '0;
            ST_LOAD:   shift_clk  = 1'b0;
            ST_SHIFT:  shift_clk  = !srf_mode;
            ST_LPULSE: begin
                line_pulse = 1'b1;
                frame_mark = line_first;
            end
            default:   pix_data   = '0;
        endcase
    end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcd_tg_pkg::*;
#(
    parameter int PIX_PER_LINE    = 320,
    parameter int LINES_PER_FRAME = 240,
    parameter int BPP             = 2,
    parameter int BUS_W           = 4,
    parameter int LPW_W           = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srf_req,
    input  logic [LPW_W-1:0] lp_width,
    input  logic             buf_valid,
    input  logic [BUS_W-1:0] buf_data,
    output logic             buf_rd,
    output logic             line_pulse,
    output logic             frame_mark,
    output logic             shift_clk,
    output logic [BUS_W-1:0] pix_data,
    output logic             srf_active
);
    localparam int WORDS = (PIX_PER_LINE * BPP) / BUS_W;

    tg_state_e state;
    logic      line_first;
    logic      pop;
    logic      frame_end;
    logic      srf_mode;

    lcd_tg_seq #(
        .WORDS (WORDS),
        .LINES (LINES_PER_FRAME),
        .LPW_W (LPW_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_valid  (buf_valid),
        .srf_mode   (srf_mode),
        .lp_width   (lp_width),
        .state      (state),
        .line_first (line_first),
        .pop        (pop),
        .frame_end  (frame_end)
    );

    lcd_tg_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .srf_req   (srf_req),
        .frame_end (frame_end),
        .srf_mode  (srf_mode)
    );

    lcd_tg_out #(
        .BUS_W (BUS_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .line_first (line_first),
        .pop        (pop),
        .frame_end  (frame_end),
        .srf_req    (srf_req),
        .srf_mode   (srf_mode),
        .buf_data   (buf_data),
        .buf_rd     (buf_rd),
        .line_pulse (line_pulse),
        .frame_mark (frame_mark),
        .shift_clk  (shift_clk),
        .pix_data   (pix_data)
    );

    assign srf_active = srf_mode;
endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk #(
    parameter int BUS_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             buf_valid,
    input logic             buf_rd,
    input logic             line_pulse,
    input logic             frame_mark,
    input logic             shift_clk,
    input logic [BUS_W-1:0] pix_data,
    input logic             srf_active
);
    a_r2_clk_single_high: assert property (@(posedge clk) disable iff (!rst_n)
        shift_clk |=> !shift_clk);

    a_r2_no_clk_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        line_pulse |-> !shift_clk);

    a_r3_frame_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_mark |-> line_pulse);

    a_r4_hold_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_clk) |-> $stable(pix_data));

    a_r4_change_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pix_data) |-> (shift_clk || srf_active));

    a_r5_read_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |-> (buf_valid && !srf_active));

    a_r7_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        srf_active |-> (!shift_clk && !buf_rd && pix_data == '0));

    // Covers both directions of the mode change (R6 and R8)
    a_r6_switch_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        (srf_active != $past(srf_active)) |-> ($past(line_pulse) && !line_pulse));
endmodule

bind lcd_timing_gen lcd_tg_chk #(.BUS_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .buf_valid  (buf_valid),
    .buf_rd     (buf_rd),
    .line_pulse (line_pulse),
    .frame_mark (frame_mark),
    .shift_clk  (shift_clk),
    .pix_data   (pix_data),
    .srf_active (srf_active)
);

// File: tb/lcd_timing_gen_tb_top.sv
module lcd_timing_gen_tb_top;
    localparam int PIX   = 8;
    localparam int LINES = 3;
    localparam int BPP   = 2;
    localparam int BUS_W = 4;
    localparam int LPW_W = 4;
    localparam int WORDS = PIX * BPP / BUS_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             srf_req = 1'b0;
    logic [LPW_W-1:0] lp_width = 4'd3;
    logic             buf_valid = 1'b0;
    logic [BUS_W-1:0] buf_data = '0;
    logic             buf_rd, line_pulse, frame_mark, shift_clk, srf_active;
    logic [BUS_W-1:0] pix_data;

    // Values applied at the next falling edge
    logic             nx_rst_n = 1'b0;
    logic             nx_req = 1'b0;
    logic [LPW_W-1:0] nx_lpw = 4'd3;
    bit               gate_en = 1'b0;
    logic [7:0]       lfsr = 8'h5A;

    // Reference model state
    bit               m_start = 1'b1;
    int               m_pos = 0;
    int               m_line = 0;
    bit               m_mode = 1'b0;
    logic [BUS_W-1:0] m_dq = '0;
    int               word_ctr = 0;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    lcd_timing_gen #(
        .PIX_PER_LINE    (PIX),
        .LINES_PER_FRAME (LINES),
        .BPP             (BPP),
        .BUS_W           (BUS_W),
        .LPW_W           (LPW_W)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .srf_req    (srf_req),
        .lp_width   (lp_width),
        .buf_valid  (buf_valid),
        .buf_data   (buf_data),
        .buf_rd     (buf_rd),
        .line_pulse (line_pulse),
        .frame_mark (frame_mark),
        .shift_clk  (shift_clk),
        .pix_data   (pix_data),
        .srf_active (srf_active)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        bit active, load, shift;
        active = (m_pos < 2 * WORDS);
        load   = active && (m_pos % 2 == 0);
        shift  = active && (m_pos % 2 == 1);
        if (m_start) begin
            chk("R1", "shift_clk",  int'(shift_clk),  0);
            chk("R1", "line_pulse", int'(line_pulse), 0);
            chk("R1", "frame_mark", int'(frame_mark), 0);
            chk("R1", "pix_data",   int'(pix_data),   0);
            chk("R1", "buf_rd",     int'(buf_rd),     0);
            chk("R1", "srf_active", int'(srf_active), 0);
        end else begin
            chk(m_mode ? "R7" : "R2", "shift_clk", int'(shift_clk), int'(shift && !m_mode));
            chk(lp_width == 0 ? "R9" : "R2", "line_pulse", int'(line_pulse), int'(!active));
            chk("R3", "frame_mark", int'(frame_mark), int'(!active && m_line == 0));
            chk(m_mode ? "R7" : "R4", "pix_data", int'(pix_data), int'(m_dq));
            chk(m_mode ? "R7" : "R5", "buf_rd", int'(buf_rd), int'(load && !m_mode && buf_valid));
            chk(srf_req ? "R6" : "R8", "srf_active", int'(srf_active), int'(m_mode));
        end
    endtask

    task automatic advance();
        int lpk;
        if (!rst_n) begin
            m_start = 1'b1; m_pos = 0; m_line = 0; m_mode = 1'b0; m_dq = '0;
        end else if (m_start) begin
            m_start = 1'b0;
        end else if (m_pos < 2 * WORDS) begin
            if (m_pos % 2 == 0) begin
                if (m_mode) m_pos++;
                else if (buf_valid) begin
                    m_dq = buf_data;
                    word_ctr++;
                    m_pos++;
                end
            end else begin
                m_pos++;
            end
        end else begin
            lpk = (lp_width == 0) ? 1 : int'(lp_width);
            if (m_pos == 2 * WORDS + lpk - 1) begin
                m_pos = 0;
                if (m_line == LINES - 1) begin
                    m_line = 0;
                    m_mode = srf_req;
                    if (srf_req) m_dq = '0;
                end else begin
                    m_line++;
                end
            end else begin
                m_pos++;
            end
        end
    endtask

    task automatic step();
        @(negedge clk);
        rst_n   = nx_rst_n;
        srf_req = nx_req;
        // lp_width only changes outside the line pulse (R2 usage rule)
        if (m_start || m_pos < 2 * WORDS) lp_width = nx_lpw;
        if (gate_en) lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        buf_valid = gate_en ? (lfsr[0] | lfsr[2]) : 1'b1;
        buf_data  = word_ctr[BUS_W-1:0];
        #1;
        if (rst_n) compare();
        advance();
    endtask

    task automatic run(input int n);
        repeat (n) step();
    endtask

    initial begin
        run(3);
        nx_rst_n = 1'b1;
        run(70);                 // normal mode, data always ready (R1..R4)
        gate_en = 1'b1;
        run(90);                 // stalling buffer (R5)
        nx_req = 1'b1;
        run(17);                 // request raised mid-frame (R6)
        nx_lpw = 4'd0;
        run(90);                 // self-refresh, single-cycle pulse (R7, R9)
        nx_lpw = 4'd3;
        run(23);
        nx_req = 1'b0;
        run(110);                // return at frame end, top of page (R8)
        nx_lpw = 4'd2;
        run(60);
        nx_req = 1'b1;
        run(80);
        nx_rst_n = 1'b0;         // reset while in self-refresh (R1)
        run(2);
        nx_rst_n = 1'b1;
        nx_req = 1'b0;
        run(80);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule